// File: doc/BRIEF.md
# Bank-Switched Floating Register Stack

This block is the register store behind a floating-point unit that keeps four separate operand stacks. Each stack holds eight 32-bit words, which the block does not interpret. Each stack has its own top pointer and its own per-slot occupancy bits. A two-byte escape instruction picks the active stack. All push, pop, stack-relative read, write and init traffic then goes to that stack only. The other three stacks keep their contents and pointers exactly as they were.

A bank change takes six clocks. During that time `ready` is low, and every request presented is ignored, so the requester must hold it until `ready` returns. A push onto a full stack, or a pop, read or write of an empty slot, does not touch storage. It raises a fault flag that stays set until reset.

The controller is a two-state machine:

- **IDLE**: `ready` is high and operations are accepted.
- **STALL**: the six-cycle bank change is running.
- **IDLE → STALL**: on an accepted bank-select instruction.
- **STALL → STALL**: while the stall counter is non-zero.
- **STALL → IDLE**: when the counter expires.

Top module: `banked_fp_stack`

## Requirements
- R1: After reset the active bank is 0, `ready` is 1, `stack_fault` is 0, `rd_data` is 0, and every bank is empty.
- R2: With `op_valid` high and `ready` high, the escape byte DBh paired with second byte E8h selects bank 0, EBh selects bank 1, EAh selects bank 2 and E9h selects bank 3. Any other byte pair leaves the bank and `ready` unchanged.
- R3: An accepted select updates `cur_bank` at the same clock edge and drives `ready` low for exactly 6 cycles. Selects and stack requests presented while `ready` is low are ignored. A select cycle performs no stack operation.
- R4: A push writes `push_data` into the slot just above the current top and makes it ST(0). The previous ST(i) becomes ST(i+1).
- R5: A pop removes ST(0). The previous ST(1) becomes ST(0).
- R6: A read of ST(`rd_idx`) loads `rd_data` at the next edge. The read sees the stack as it was before any push or pop in the same cycle. A read of an empty slot sets the fault and leaves `rd_data` unchanged. `rd_data` changes only after a read.
- R7: A write replaces ST(`wr_idx`) if that slot is occupied. Otherwise it sets the fault and changes nothing.
- R8: A push onto a bank holding 8 values sets the fault and leaves the bank's contents and top unchanged.
- R9: A pop of an empty bank sets the fault.
- R10: `init_en` empties the active bank only.
- R11: Switching away from a bank and back preserves its contents and order exactly. Bank 3 can be selected, pushed and read like the others.
- R12: `stack_fault` stays set until reset.
- R13: When several of init, push, pop and write are requested in one cycle, only the highest-priority one is performed, in the order init, push, pop, write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction bytes valid |
| op_byte0 | input | 8 | First instruction byte (escape) |
| op_byte1 | input | 8 | Second instruction byte (bank code) |
| init_en | input | 1 | Empty the active bank |
| push_en | input | 1 | Push request |
| push_data | input | WIDTH | Word to push |
| pop_en | input | 1 | Pop request |
| wr_en | input | 1 | Write request |
| wr_idx | input | PW | Stack-relative write slot |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request |
| rd_idx | input | PW | Stack-relative read slot |
| ready | output | 1 | High when requests are accepted |
| cur_bank | output | 2 | Active bank |
| rd_data | output | WIDTH | Last word read |
| stack_fault | output | 1 | Sticky stack-fault flag |

## Verification
A wrong top pointer or occupancy bit in any bank is invisible until that bank is active again. It then shows at the next read as wrong `rd_data` or as a spurious or missing fault one edge after the read. For this reason the bench fills one bank, works in two others, and returns to read it back. A miscounting stall counter shows directly as a `ready` low pulse that is not six cycles long. A wrong bank code decode shows in `cur_bank` one edge after the select.

// File: rtl/bstk_pkg.sv
package bstk_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;

    localparam logic [7:0] OPC_ESC   = 8'hDB;
    localparam logic [7:0] OPC_BANK0 = 8'hE8;
    localparam logic [7:0] OPC_BANK1 = 8'hEB;
    localparam logic [7:0] OPC_BANK2 = 8'hEA;
    localparam logic [7:0] OPC_BANK3 = 8'hE9;

    typedef enum logic [0:0] {
        SW_IDLE  = 1'b0,
        SW_STALL = 1'b1
    } sw_state_e;
endpackage

// File: rtl/bstk_opdec.sv
module bstk_opdec
    import bstk_pkg::*;
(
    input  logic              op_valid,
    input  logic [7:0]        op_byte0,
    input  logic [7:0]        op_byte1,
    output logic              sel_hit,
    output logic [BANK_W-1:0] sel_bank
);
    always_comb begin
        sel_hit  = 1'b0;
        sel_bank = '0;
        if (op_valid && op_byte0 == OPC_ESC) begin
            unique case (op_byte1)
                OPC_BANK0: begin sel_hit = 1'b1; sel_bank = 2'd0; end
                OPC_BANK1: begin sel_hit = 1'b1; sel_bank = 2'd1; end
                OPC_BANK2: begin sel_hit = 1'b1; sel_bank = 2'd2; end
                OPC_BANK3: begin sel_hit = 1'b1; sel_bank = 2'd3; end
                default:   begin sel_hit = 1'b0; sel_bank = '0;   end
            endcase
        end
    end
endmodule

// File: rtl/bstk_switch_fsm.sv
module bstk_switch_fsm
    import bstk_pkg::*;
#(
    parameter int SWITCH_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_hit,
    input  logic [BANK_W-1:0] sel_bank,
    output logic              ready,
    output logic [BANK_W-1:0] cur_bank
);
    localparam int CNT_W = (SWITCH_CYCLES > 1) ? $clog2(SWITCH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SWITCH_CYCLES - 1);

    sw_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BANK_W-1:0] bank_q, bank_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            cnt_q   <= '0;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bank_q  <= bank_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bank_d  = bank_q;
        unique case (state_q)
            SW_IDLE: begin
                if (sel_hit) begin
                    state_d = SW_STALL;
                    cnt_d   = CNT_LOAD;
                    bank_d  = sel_bank;
                end
            end
            SW_STALL: begin
                if (cnt_q == '0) begin
                    state_d = SW_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready    = (state_q == SW_IDLE);
        cur_bank = bank_q;
    end
endmodule

// File: rtl/bstk_bank.sv
module bstk_bank #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             do_init,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic             do_wr,
    input  logic [WIDTH-1:0] push_data,
    input  logic [PW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_word,
    output logic             rd_live,
    output logic             wr_live,
    output logic             full,
    output logic             top_live
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [PW-1:0]    top_q;
    logic [PW-1:0]    rd_slot, wr_slot, push_slot;

    always_comb begin
        rd_slot   = top_q + rd_idx;
        wr_slot   = top_q + wr_idx;
        push_slot = top_q - PW'(1);
        rd_word   = mem[rd_slot];
        rd_live   = valid_q[rd_slot];
        wr_live   = valid_q[wr_slot];
        full      = &valid_q;
        top_live  = valid_q[top_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q   <= '0;
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (en) begin
            if (do_init) begin
                top_q   <= '0;
                valid_q <= '0;
            end else if (do_push && !full) begin
                top_q              <= push_slot;
                mem[push_slot]     <= push_data;
                valid_q[push_slot] <= 1'b1;
            end else if (do_pop && top_live) begin
                valid_q[top_q] <= 1'b0;
                top_q          <= top_q + PW'(1);
            end else if (do_wr && wr_live) begin
                mem[wr_slot] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/banked_fp_stack.sv
module banked_fp_stack
    import bstk_pkg::*;
#(
    parameter int DEPTH         = 8,
    parameter int WIDTH         = 32,
    parameter int SWITCH_CYCLES = 6,
    localparam int PW           = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte0,
    input  logic [7:0]        op_byte1,
    input  logic              init_en,
    input  logic              push_en,
    input  logic [WIDTH-1:0]  push_data,
    input  logic              pop_en,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [PW-1:0]     rd_idx,
    output logic              ready,
    output logic [BANK_W-1:0] cur_bank,
    output logic [WIDTH-1:0]  rd_data,
    output logic              stack_fault
);
    logic              sel_hit;
    logic [BANK_W-1:0] sel_bank;
    logic              go, op_init, op_push, op_pop, op_wr, op_rd;
    logic              fault_set;

    logic [WIDTH-1:0]  rd_word_a [NUM_BANKS];
    logic              rd_live_a [NUM_BANKS];
    logic              wr_live_a [NUM_BANKS];
    logic              full_a    [NUM_BANKS];
    logic              top_live_a[NUM_BANKS];

    bstk_opdec u_dec (
        .op_valid (op_valid),
        .op_byte0 (op_byte0),
        .op_byte1 (op_byte1),
        .sel_hit  (sel_hit),
        .sel_bank (sel_bank)
    );

    bstk_switch_fsm #(.SWITCH_CYCLES(SWITCH_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_hit  (sel_hit),
        .sel_bank (sel_bank),
        .ready    (ready),
        .cur_bank (cur_bank)
    );

    // one stack operation per cycle, init > push > pop > write
    always_comb begin
        go      = ready && !sel_hit;
        op_init = go && init_en;
        op_push = go && push_en && !init_en;
        op_pop  = go && pop_en && !init_en && !push_en;
        op_wr   = go && wr_en && !init_en && !push_en && !pop_en;
        op_rd   = go && rd_en;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bstk_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cur_bank == BANK_W'(b)),
            .do_init   (op_init),
            .do_push   (op_push),
            .do_pop    (op_pop),
            .do_wr     (op_wr),
            .push_data (push_data),
            .wr_idx    (wr_idx),
            .wr_data   (wr_data),
            .rd_idx    (rd_idx),
            .rd_word   (rd_word_a[b]),
            .rd_live   (rd_live_a[b]),
            .wr_live   (wr_live_a[b]),
            .full      (full_a[b]),
            .top_live  (top_live_a[b])
        );
    end

    always_comb begin
        fault_set = (op_push && full_a[cur_bank])
                 || (op_pop  && !top_live_a[cur_bank])
                 || (op_wr   && !wr_live_a[cur_bank])
                 || (op_rd   && !rd_live_a[cur_bank]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            stack_fault <= 1'b0;
        end else begin
            if (op_rd && rd_live_a[cur_bank]) rd_data <= rd_word_a[cur_bank];
            if (fault_set) stack_fault <= 1'b1;
        end
    end
endmodule

// File: rtl/bstk_checker.sv
module bstk_checker #(
    parameter int SWITCH_CYCLES = 6,
    parameter int WIDTH         = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             op_valid,
    input logic [7:0]       op_byte0,
    input logic [7:0]       op_byte1,
    input logic             rd_en,
    input logic [1:0]       cur_bank,
    input logic [WIDTH-1:0] rd_data,
    input logic             stack_fault
);
    localparam int LW = $clog2(SWITCH_CYCLES + 2) + 1;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) low_cnt <= '0;
        else if (ready) low_cnt <= '0;
        else if (low_cnt != '1) low_cnt <= low_cnt + LW'(1);
    end

    logic sel_seen;
    assign sel_seen = ready && op_valid && op_byte0 == 8'hDB && op_byte1[7:2] == 6'b111010;

    AST_SEL_STALLS: assert property (@(posedge clk) disable iff (!rst_n) sel_seen |=> !ready); // R3
    AST_SEL_BANK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_seen |=> (cur_bank + $past(op_byte1[1:0])) == 2'd0); // R2
    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_valid && op_byte0 != 8'hDB) |=> ready); // R2
    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(cur_bank)); // R3
    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(low_cnt) <= SWITCH_CYCLES); // R3
    AST_STALL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> int'(low_cnt) == SWITCH_CYCLES); // R3
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_fault |=> stack_fault); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R6
endmodule

bind banked_fp_stack bstk_checker #(.SWITCH_CYCLES(SWITCH_CYCLES), .WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .op_valid    (op_valid),
    .op_byte0    (op_byte0),
    .op_byte1    (op_byte1),
    .rd_en       (rd_en),
    .cur_bank    (cur_bank),
    .rd_data     (rd_data),
    .stack_fault (stack_fault)
);

// File: tb/banked_fp_stack_tb_top.sv
`timescale 1ns/1ps
module banked_fp_stack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte0 = '0, op_byte1 = '0;
    logic        init_en = 1'b0, push_en = 1'b0, pop_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] push_data = '0, wr_data = '0;
    logic [2:0]  wr_idx = '0, rd_idx = '0;
    logic        ready;
    logic [1:0]  cur_bank;
    logic [31:0] rd_data;
    logic        stack_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    banked_fp_stack dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte0(op_byte0), .op_byte1(op_byte1),
        .init_en(init_en), .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
        .ready(ready), .cur_bank(cur_bank), .rd_data(rd_data), .stack_fault(stack_fault)
    );

    typedef struct packed {
        logic [1:0]  cmd;   // 0 push, 1 pop, 2 read, 3 write
        logic [2:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 32'hA1A1_0001, 32'h0},
        '{2'd0, 3'd0, 32'hA2A2_0002, 32'h0},
        '{2'd0, 3'd0, 32'hA3A3_0003, 32'h0},
        '{2'd2, 3'd0, 32'h0,         32'hA3A3_0003},
        '{2'd2, 3'd2, 32'h0,         32'hA1A1_0001},
        '{2'd1, 3'd0, 32'h0,         32'h0},
        '{2'd2, 3'd0, 32'h0,         32'hA2A2_0002},
        '{2'd3, 3'd1, 32'hB1B1_0011, 32'h0},
        '{2'd2, 3'd1, 32'h0,         32'hB1B1_0011},
        '{2'd2, 3'd0, 32'h0,         32'hA2A2_0002}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_push(input logic [31:0] d);
        push_en = 1'b1; push_data = d;
        @(negedge clk);
        push_en = 1'b0;
    endtask

    task automatic do_pop();
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] i);
        rd_en = 1'b1; rd_idx = i;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_sel(input logic [7:0] b0, input logic [7:0] b1);
        op_valid = 1'b1; op_byte0 = b0; op_byte1 = b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 20 && !ready; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n_low;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 bank", 32'(cur_bank), 32'd0);
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 fault", 32'(stack_fault), 32'd0);
        check("R1 rd_data", rd_data, 32'h0);
        do_read(3'd0);
        check("R1 empty read faults", 32'(stack_fault), 32'd1);
        check("R6 rd_data kept on empty read", rd_data, 32'h0);
        do_reset();

        // R4 R5 R6 R7 vector walk in bank 0
        for (int v = 0; v < NV; v++) begin
            unique case (VEC[v].cmd)
                2'd0: do_push(VEC[v].data);
                2'd1: do_pop();
                2'd2: begin
                    do_read(VEC[v].idx);
                    check($sformatf("R4/R5/R6/R7 vector %0d", v), rd_data, VEC[v].exp);
                end
                default: do_write(VEC[v].idx, VEC[v].data);
            endcase
        end
        check("R4 no fault in vectors", 32'(stack_fault), 32'd0);

        // R2 foreign codes ignored
        do_sel(8'hDB, 8'hE7);
        check("R2 foreign second byte ready", 32'(ready), 32'd1);
        do_sel(8'hDA, 8'hEB);
        check("R2 foreign escape ready", 32'(ready), 32'd1);
        check("R2 foreign bank", 32'(cur_bank), 32'd0);

        // R2 R3 select bank 1, stall length, ignored requests
        do_sel(8'hDB, 8'hEB);
        check("R2 bank1 code", 32'(cur_bank), 32'd1);
        n_low = ready ? 0 : 1;
        push_en = 1'b1; push_data = 32'hDEAD_0000;
        op_valid = 1'b1; op_byte0 = 8'hDB; op_byte1 = 8'hE8;
        @(negedge clk);
        push_en = 1'b0; op_valid = 1'b0;
        if (!ready) n_low++;
        for (int k = 0; k < 12 && !ready; k++) begin
            @(negedge clk);
            if (!ready) n_low++;
        end
        check("R3 stall length", 32'(n_low), 32'd6);
        check("R3 select in stall ignored", 32'(cur_bank), 32'd1);

        // R8 boundary: eight pushes fit (stalled push was dropped)
        for (int k = 0; k < 8; k++) do_push(32'hC000_0000 + 32'(k));
        check("R3/R8 eight pushes no fault", 32'(stack_fault), 32'd0);
        do_read(3'd0);
        check("R4 bank1 ST0", rd_data, 32'hC000_0007);
        do_read(3'd7);
        check("R4 bank1 ST7", rd_data, 32'hC000_0000);

        // R11 bank 3 usable
        do_sel(8'hDB, 8'hE9); wait_ready();
        check("R2 bank3 code", 32'(cur_bank), 32'd3);
        do_push(32'hD0D0_0003);
        do_read(3'd0);
        check("R11 bank3 read", rd_data, 32'hD0D0_0003);

        // R10 init in bank 2 only
        do_sel(8'hDB, 8'hEA); wait_ready();
        check("R2 bank2 code", 32'(cur_bank), 32'd2);
        do_push(32'hE0E0_0002);
        init_en = 1'b1; @(negedge clk); init_en = 1'b0;
        do_sel(8'hDB, 8'hEB); wait_ready();
        do_read(3'd0);
        check("R10/R11 bank1 intact", rd_data, 32'hC000_0007);
        do_sel(8'hDB, 8'hE8); wait_ready();
        do_read(3'd1);
        check("R11 bank0 ST1 intact", rd_data, 32'hB1B1_0011);
        do_read(3'd0);
        check("R11 bank0 ST0 intact", rd_data, 32'hA2A2_0002);
        check("R10 no fault yet", 32'(stack_fault), 32'd0);
        do_sel(8'hDB, 8'hEA); wait_ready();
        do_read(3'd0);
        check("R10 bank2 emptied", 32'(stack_fault), 32'd1);
        check("R6 rd_data kept", rd_data, 32'hA2A2_0002);
        repeat (5) @(negedge clk);
        check("R12 fault sticky", 32'(stack_fault), 32'd1);

        // R8 overflow leaves storage
        do_sel(8'hDB, 8'hEB); wait_ready();
        do_push(32'hF0F0_0009);
        do_read(3'd0);
        check("R8 overflow storage unchanged", rd_data, 32'hC000_0007);

        // R9 underflow
        do_reset();
        do_pop();
        check("R9 pop empty faults", 32'(stack_fault), 32'd1);

        // R7 write empty slot
        do_reset();
        do_write(3'd0, 32'h1234_5678);
        check("R7 write empty faults", 32'(stack_fault), 32'd1);

        // R13 priority and R6 read-before-push
        do_reset();
        do_push(32'h5000_0000);
        push_en = 1'b1; pop_en = 1'b1; push_data = 32'h5000_0001;
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0;
        do_read(3'd0);
        check("R13 push beats pop ST0", rd_data, 32'h5000_0001);
        do_read(3'd1);
        check("R13 push beats pop ST1", rd_data, 32'h5000_0000);
        rd_en = 1'b1; rd_idx = 3'd0; push_en = 1'b1; push_data = 32'h5000_0002;
        @(negedge clk);
        rd_en = 1'b0; push_en = 1'b0;
        check("R6 read sees pre-push ST0", rd_data, 32'h5000_0001);
        init_en = 1'b1; push_en = 1'b1; push_data = 32'h5000_0003;
        @(negedge clk);
        init_en = 1'b0; push_en = 1'b0;
        check("R13 no fault before empty read", 32'(stack_fault), 32'd0);
        do_read(3'd0);
        check("R13 init beats push", 32'(stack_fault), 32'd1);

        // R1 reset during a stall
        do_sel(8'hDB, 8'hE9);
        do_reset();
        check("R1 bank after reset in stall", 32'(cur_bank), 32'd0);
        check("R1 ready after reset in stall", 32'(ready), 32'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule